// File: doc/BRIEF.md
# CRT Character Raster Timing Generator

This block produces the raster timing for a character-cell display. Every clock is one character time. A horizontal counter steps across each scanline, a row address steps through the scanlines of a character row, and a row counter steps through the character rows of a frame. Optional extra scanlines can follow the last row before the next frame starts. From these counters the block drives display enable, horizontal sync, vertical sync, a refresh address for the character memory and the scanline number within the current row.

All timing values arrive as a parallel set of static inputs. These are the line length, visible width, sync positions, a packed sync-width byte, scanlines per row, frame length in rows, visible rows, extra scanlines, start address and display-enable delay. The surrounding logic holds these inputs steady while the block runs, and changes them only while reset is high. The elaboration parameter `VARIANT` picks one of four sync-width behaviours. The block updates its outputs once per clock, and all outputs come straight from registers.

Top module: `crt_char_timer`

## Requirements
- R1: The character counter returns to 0 on the clock after it equals `h_total`. On every other clock it increases by one.
- R2: In the clock where the character counter equals `h_disp`, horizontal visibility ends and the refresh address at that moment is held. The next character row starts its refresh addresses from the held value.
- R3: `ma` increases by one each clock, modulo 2^14. The exception is the clock after a line end (counter equal to `h_total`), when `ma` is reloaded with the start address of the next line.
- R4: `hsync` rises only in a clock where the character counter equals `hs_pos`.
- R5: The pulse width w is `sync_w[3:0]`. In variants 0 and 1, `hsync` stays high for w clocks, so w = 0 gives no pulse. In variants 2 and 3, the 4-bit width counter steps before it is compared, so `hsync` stays high for (w + 15) mod 16 clocks.
- R6: At each line end, `ra` returns to 0 when it equals `max_scan` and otherwise increases by one. It does not move during extra scanlines.
- R7: After the row numbered `v_total` completes with a nonzero `v_adj`, exactly `v_adj` extra scanlines follow before the frame ends. A frame therefore lasts (`v_total`+1)×(`max_scan`+1)+`v_adj` lines of `h_total`+1 clocks.
- R8: With `v_adj` = 0 the frame ends at the end of row `v_total`. At every frame end the row counter clears, line visibility returns and `ma` reloads from `start_addr`.
- R9: `vsync` rises only at the start of a row whose 7-bit row number equals `vs_pos`, with `ra` = 0. Line visibility ends from the row whose number equals `v_disp`.
- R10: In variants 0 and 3, `vsync` lasts `sync_w[7:4]` lines, with 0 counting as 16. In variants 1 and 2 it always lasts 16 lines.
- R11: `disp_en` is horizontal visibility delayed by `skew_sel` characters (0, 1 and 2 give that many; 3 gives 0), ANDed with line visibility. Variants 1 and 2 ignore `skew_sel` and use no delay.
- R12: While `rst` is high, `disp_en`, `hsync` and `vsync` are low, `ra` is 0 and `ma` equals `start_addr`. The frame starts from row 0 when `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| h_total | input | 8 | Last character index of a scanline |
| h_disp | input | 8 | Character count at which visibility ends |
| hs_pos | input | 8 | Character index where hsync begins |
| sync_w | input | 8 | Low nibble hsync width, high nibble vsync width |
| v_total | input | 7 | Last character row of a frame |
| v_disp | input | 7 | Row number where visible rows end |
| vs_pos | input | 7 | Row number where vsync begins |
| v_adj | input | 5 | Extra scanlines after the last row |
| max_scan | input | 5 | Last scanline index within a row |
| start_addr | input | 14 | Refresh address at the start of a frame |
| skew_sel | input | 2 | Display enable delay select |
| disp_en | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| ma | output | 14 | Refresh (memory) address |
| ra | output | 5 | Scanline within the character row |

## Verification
The bench builds two copies side by side on the same inputs, one with `VARIANT` = 0 and one with `VARIANT` = 2. This makes both hsync width rules and both vsync width rules observable in the same runs. The zero-width hsync cancellation and the 15-clock pulse for a zero width can be compared directly. Because the second copy ignores the delay select, the difference between the two first display-enable edges measures the skew. Three timing sets cover extra scanlines, an immediate frame end, a refresh address that wraps past 2^14 and the unused delay code 3.

// File: rtl/crt_char_timer.sv
module crt_char_timer #(
  parameter int VARIANT = 0,
  parameter int MA_W    = 14,
  parameter int RA_W    = 5,
  parameter int HC_W    = 8,
  parameter int VC_W    = 7,
  parameter int SW_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HC_W-1:0]   h_total,
  input  logic [HC_W-1:0]   h_disp,
  input  logic [HC_W-1:0]   hs_pos,
  input  logic [2*SW_W-1:0] sync_w,
  input  logic [VC_W-1:0]   v_total,
  input  logic [VC_W-1:0]   v_disp,
  input  logic [VC_W-1:0]   vs_pos,
  input  logic [RA_W-1:0]   v_adj,
  input  logic [RA_W-1:0]   max_scan,
  input  logic [MA_W-1:0]   start_addr,
  input  logic [1:0]        skew_sel,
  output logic              disp_en,
  output logic              hsync,
  output logic              vsync,
  output logic [MA_W-1:0]   ma,
  output logic [RA_W-1:0]   ra
);

  localparam logic ZERO_HS = (VARIANT == 0) || (VARIANT == 1);
  localparam logic PROG_VS = (VARIANT == 0) || (VARIANT == 3);
  localparam logic SKEW_OK = PROG_VS;
  localparam logic [HC_W-1:0] HC_ONE = 1;
  localparam logic [VC_W-1:0] VC_ONE = 1;
  localparam logic [RA_W-1:0] RA_ONE = 1;
  localparam logic [MA_W-1:0] MA_ONE = 1;
  localparam logic [SW_W-1:0] SW_ONE = 1;

  logic [HC_W-1:0] cc, n_cc;
  logic [VC_W-1:0] lc, n_lc;
  logic [RA_W-1:0] n_ra;
  logic [MA_W-1:0] n_ma, line_addr, n_line, eol_addr, n_eol;
  logic [SW_W-1:0] hsc, n_hsc, vsc, n_vsc;
  logic [2:0]      shf, n_shf, skew_mask;
  logic hvis, n_hvis, lvis, n_lvis, adj, n_adj;
  logic n_hs, n_vs, n_de, frame_end;

  assign skew_mask = !SKEW_OK            ? 3'b001 :
                     (skew_sel == 2'd1)  ? 3'b010 :
                     (skew_sel == 2'd2)  ? 3'b100 : 3'b001;

  always_comb begin
    n_cc = cc;  n_lc = lc;  n_ra = ra;  n_ma = ma;
    n_line = line_addr;  n_eol = eol_addr;
    n_hvis = hvis;  n_lvis = lvis;  n_adj = adj;
    n_hs = hsync;  n_hsc = hsc;  n_vs = vsync;  n_vsc = vsc;
    frame_end = 1'b0;

    if (cc == h_disp) begin
      n_hvis = 1'b0;
      n_eol  = ma;
    end
    n_shf = {shf[1:0], n_hvis};
    n_de  = (|(n_shf & skew_mask)) && lvis;
    n_ma  = ma + MA_ONE;

    if (cc == h_total) begin
      n_cc = '0;
      if (vsync) begin
        n_vsc = vsc + SW_ONE;
        n_vs  = PROG_VS ? (n_vsc != sync_w[2*SW_W-1:SW_W]) : (n_vsc != '0);
      end
      if (adj) begin
        n_lc = lc + VC_ONE;
        if (n_lc == VC_W'(v_adj)) begin
          n_adj     = 1'b0;
          frame_end = 1'b1;
        end
      end else if (ra == max_scan) begin
        n_ra   = '0;
        n_line = n_eol;
        if (lc == v_total) begin
          if (v_adj != '0) begin
            n_lc  = '0;
            n_adj = 1'b1;
          end else begin
            frame_end = 1'b1;
          end
        end else begin
          n_lc = lc + VC_ONE;
          if (n_lc == vs_pos) begin
            n_vs  = 1'b1;
            n_vsc = '0;
          end
          if (n_lc == v_disp) n_lvis = 1'b0;
        end
      end else begin
        n_ra = ra + RA_ONE;
      end
      if (frame_end) begin
        n_lc   = '0;
        n_lvis = 1'b1;
        n_line = start_addr;
      end
      n_ma   = n_line;
      n_hvis = 1'b1;
    end else begin
      n_cc = cc + HC_ONE;
    end

    if (n_cc == hs_pos) begin
      n_hsc = '0;
      n_hs  = 1'b1;
    end
    if (n_hs) begin
      if (ZERO_HS) begin
        n_hs  = n_hsc != sync_w[SW_W-1:0];
        n_hsc = n_hsc + SW_ONE;
      end else begin
        n_hsc = n_hsc + SW_ONE;
        n_hs  = n_hsc != sync_w[SW_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc <= '0;  lc <= '0;  ra <= '0;
      ma <= start_addr;  line_addr <= start_addr;  eol_addr <= start_addr;
      hvis <= 1'b1;  lvis <= 1'b1;  adj <= 1'b0;  shf <= '0;
      hsync <= 1'b0;  hsc <= '0;  vsync <= 1'b0;  vsc <= '0;
      disp_en <= 1'b0;
    end else begin
      cc <= n_cc;  lc <= n_lc;  ra <= n_ra;
      ma <= n_ma;  line_addr <= n_line;  eol_addr <= n_eol;
      hvis <= n_hvis;  lvis <= n_lvis;  adj <= n_adj;  shf <= n_shf;
      hsync <= n_hs;  hsc <= n_hsc;  vsync <= n_vs;  vsc <= n_vsc;
      disp_en <= n_de;
    end
  end

endmodule

// File: rtl/crt_char_timer_chk.sv
module crt_char_timer_chk #(
  parameter int MA_W = 14,
  parameter int RA_W = 5,
  parameter int HC_W = 8,
  parameter int VC_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic [HC_W-1:0] h_total,
  input logic [HC_W-1:0] hs_pos,
  input logic [VC_W-1:0] vs_pos,
  input logic [HC_W-1:0] cc,
  input logic [VC_W-1:0] lc,
  input logic [RA_W-1:0] ra,
  input logic [MA_W-1:0] ma,
  input logic            hsync,
  input logic            vsync,
  input logic            disp_en,
  input logic            lvis
);

  localparam logic [HC_W-1:0] HC_ONE = 1;
  localparam logic [RA_W-1:0] RA_ONE = 1;
  localparam logic [MA_W-1:0] MA_ONE = 1;

  AST_CC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cc == h_total) |=> (cc == '0)); // R1
  AST_CC_STEP: assert property (@(posedge clk) disable iff (rst)
    (cc != h_total) |=> (cc == $past(cc) + HC_ONE)); // R1
  AST_MA_STEP: assert property (@(posedge clk) disable iff (rst)
    (cc != h_total) |=> (ma == $past(ma) + MA_ONE)); // R3
  AST_HS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> (cc == hs_pos)); // R4
  AST_RA_STEP: assert property (@(posedge clk) disable iff (rst)
    (ra != $past(ra)) |-> (ra == '0 || ra == $past(ra) + RA_ONE)); // R6
  AST_VS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (lc == vs_pos && ra == '0 && cc == '0)); // R9
  AST_DE_LINE: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> $past(lvis)); // R11

endmodule

bind crt_char_timer crt_char_timer_chk #(
  .MA_W(MA_W), .RA_W(RA_W), .HC_W(HC_W), .VC_W(VC_W)
) chk (
  .clk(clk), .rst(rst), .h_total(h_total), .hs_pos(hs_pos), .vs_pos(vs_pos),
  .cc(cc), .lc(lc), .ra(ra), .ma(ma), .hsync(hsync), .vsync(vsync),
  .disp_en(disp_en), .lvis(lvis)
);

// File: tb/crt_char_timer_test.sv
module crt_char_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0]  h_total, h_disp, hs_pos, sync_w;
  logic [6:0]  v_total, v_disp, vs_pos;
  logic [4:0]  v_adj, max_scan;
  logic [13:0] start_addr;
  logic [1:0]  skew_sel;
  logic [1:0]  de, hs, vs;
  logic [13:0] ma [2];
  logic [4:0]  ra [2];

  crt_char_timer #(.VARIANT(0)) uut (
    .clk(clk), .rst(rst), .h_total(h_total), .h_disp(h_disp), .hs_pos(hs_pos),
    .sync_w(sync_w), .v_total(v_total), .v_disp(v_disp), .vs_pos(vs_pos),
    .v_adj(v_adj), .max_scan(max_scan), .start_addr(start_addr), .skew_sel(skew_sel),
    .disp_en(de[0]), .hsync(hs[0]), .vsync(vs[0]), .ma(ma[0]), .ra(ra[0]));

  crt_char_timer #(.VARIANT(2)) uut_b (
    .clk(clk), .rst(rst), .h_total(h_total), .h_disp(h_disp), .hs_pos(hs_pos),
    .sync_w(sync_w), .v_total(v_total), .v_disp(v_disp), .vs_pos(vs_pos),
    .v_adj(v_adj), .max_scan(max_scan), .start_addr(start_addr), .skew_sel(skew_sel),
    .disp_en(de[1]), .hsync(hs[1]), .vsync(vs[1]), .ma(ma[1]), .ra(ra[1]));

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int k, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s inst%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  // Behavioural reference: one step per character clock
  int m_cc[2], m_lc[2], m_ra[2], m_ma[2], m_line[2], m_eol[2], m_hsc[2], m_vsc[2];
  bit m_hvis[2], m_lvis[2], m_hs[2], m_vs[2], m_adj[2], m_de[2];
  bit vhist0[$], vhist1[$];
  int variant_of[2] = '{0, 2};

  task automatic m_reset(input int k);
    m_cc[k] = 0; m_lc[k] = 0; m_ra[k] = 0;
    m_ma[k] = start_addr; m_line[k] = start_addr; m_eol[k] = start_addr;
    m_hvis[k] = 1; m_lvis[k] = 1; m_adj[k] = 0;
    m_hs[k] = 0; m_hsc[k] = 0; m_vs[k] = 0; m_vsc[k] = 0; m_de[k] = 0;
    if (k == 0) vhist0 = '{0, 0, 0}; else vhist1 = '{0, 0, 0};
  endtask

  task automatic m_step(input int k);
    bit zw   = variant_of[k] <= 1;
    bit prog = (variant_of[k] == 0) || (variant_of[k] == 3);
    int dly  = (prog && skew_sel != 3) ? int'(skew_sel) : 0;
    bit fe   = 0;
    bit vis;
    if (m_cc[k] == h_disp) begin m_hvis[k] = 0; m_eol[k] = m_ma[k]; end
    if (k == 0) begin vhist0.push_front(m_hvis[k]); void'(vhist0.pop_back()); vis = vhist0[dly]; end
    else        begin vhist1.push_front(m_hvis[k]); void'(vhist1.pop_back()); vis = vhist1[dly]; end
    m_de[k] = vis && m_lvis[k];
    m_ma[k] = (m_ma[k] + 1) % 16384;
    if (m_cc[k] == h_total) begin
      m_cc[k] = 0;
      if (m_vs[k]) begin
        m_vsc[k] = (m_vsc[k] + 1) % 16;
        m_vs[k] = prog ? (m_vsc[k] != sync_w[7:4]) : (m_vsc[k] != 0);
      end
      if (m_adj[k]) begin
        m_lc[k] = (m_lc[k] + 1) % 128;
        if (m_lc[k] == v_adj) begin m_adj[k] = 0; fe = 1; end
      end else if (m_ra[k] == max_scan) begin
        m_ra[k] = 0;
        m_line[k] = m_eol[k];
        if (m_lc[k] == v_total) begin
          if (v_adj != 0) begin m_lc[k] = 0; m_adj[k] = 1; end
          else fe = 1;
        end else begin
          m_lc[k] = (m_lc[k] + 1) % 128;
          if (m_lc[k] == vs_pos) begin m_vs[k] = 1; m_vsc[k] = 0; end
          if (m_lc[k] == v_disp) m_lvis[k] = 0;
        end
      end else m_ra[k] = (m_ra[k] + 1) % 32;
      if (fe) begin m_lc[k] = 0; m_lvis[k] = 1; m_line[k] = start_addr; end
      m_ma[k] = m_line[k];
      m_hvis[k] = 1;
    end else m_cc[k] = (m_cc[k] + 1) % 256;
    if (m_cc[k] == hs_pos) begin m_hsc[k] = 0; m_hs[k] = 1; end
    if (m_hs[k]) begin
      if (zw) begin m_hs[k] = m_hsc[k] != sync_w[3:0]; m_hsc[k] = (m_hsc[k] + 1) % 16; end
      else    begin m_hsc[k] = (m_hsc[k] + 1) % 16; m_hs[k] = m_hsc[k] != sync_w[3:0]; end
    end
  endtask

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst) m_reset(k); else m_step(k);
    end
  end

  // Event trackers and per-configuration expectations
  int cyc;
  int exp_hsw[2], exp_vsw[2], exp_frame[2], hs_len[2], vs_len[2], hs_rises[2];
  int last_vs[2], first_de[2];
  bit p_hs[2], p_vs[2], p_de[2];
  int p_ma0, p_ra0;
  bit seen_wrap, row_done, want_row;
  string frame_tag;

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      for (int k = 0; k < 2; k++) begin
        check("R11 disp_en", k, de[k] == m_de[k], de[k], m_de[k]);
        check("R4 hsync",    k, hs[k] == m_hs[k], hs[k], m_hs[k]);
        check("R9 vsync",    k, vs[k] == m_vs[k], vs[k], m_vs[k]);
        check("R3 ma",       k, ma[k] == m_ma[k], ma[k], m_ma[k]);
        check("R6 ra",       k, ra[k] == m_ra[k], ra[k], m_ra[k]);
        if (hs[k] && !p_hs[k]) begin hs_rises[k]++; hs_len[k] = 0; end
        if (hs[k]) hs_len[k]++;
        if (!hs[k] && p_hs[k]) check("R5 hsync width", k, hs_len[k] == exp_hsw[k], hs_len[k], exp_hsw[k]);
        if (vs[k] && !p_vs[k]) begin
          if (last_vs[k] >= 0 && exp_frame[k] > 0)
            check(frame_tag, k, cyc - last_vs[k] == exp_frame[k], cyc - last_vs[k], exp_frame[k]);
          last_vs[k] = cyc;
          vs_len[k] = 0;
        end
        if (vs[k]) vs_len[k]++;
        if (!vs[k] && p_vs[k] && exp_vsw[k] > 0)
          check("R10 vsync width", k, vs_len[k] == exp_vsw[k], vs_len[k], exp_vsw[k]);
        if (de[k] && !p_de[k] && first_de[k] < 0) first_de[k] = cyc;
        p_hs[k] = hs[k]; p_vs[k] = vs[k]; p_de[k] = de[k];
      end
      if (p_ma0 == 16383 && ma[0] == 0) seen_wrap = 1;
      if (want_row && !row_done && p_ra0 == 1 && ra[0] == 0) begin
        row_done = 1;
        check("R2 row start", 0, ma[0] == 14'(start_addr + 14'(h_disp)), ma[0], 14'(start_addr + 14'(h_disp)));
      end
      p_ma0 = ma[0]; p_ra0 = ra[0];
    end
  endtask

  task automatic start_cfg();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check("R12 reset de", k, de[k] == 0, de[k], 0);
      check("R12 reset hs", k, hs[k] == 0, hs[k], 0);
      check("R12 reset vs", k, vs[k] == 0, vs[k], 0);
      check("R12 reset ma", k, ma[k] == start_addr, ma[k], start_addr);
      check("R12 reset ra", k, ra[k] == 0, ra[k], 0);
      hs_len[k] = 0; vs_len[k] = 0; hs_rises[k] = 0;
      last_vs[k] = -1; first_de[k] = -1;
      p_hs[k] = 0; p_vs[k] = 0; p_de[k] = 0;
    end
    p_ma0 = start_addr; p_ra0 = 0;
    seen_wrap = 0; row_done = 0; cyc = 0;
    rst = 1'b0;
  endtask

  task automatic end_cfg(input int skew_diff);
    for (int k = 0; k < 2; k++) begin
      if (exp_hsw[k] == 0) check("R5 no hsync", k, hs_rises[k] == 0, hs_rises[k], 0);
      else                 check("R4 hsync seen", k, hs_rises[k] > 0, hs_rises[k], 1);
    end
    check("R11 skew delay", 0, first_de[0] - first_de[1] == skew_diff, first_de[0] - first_de[1], skew_diff);
  endtask

  initial begin
    want_row = 0;
    // Set A: extra scanlines, address wrap, skew 1
    h_total = 9; h_disp = 6; hs_pos = 7; sync_w = 8'h32;
    v_total = 5; v_disp = 4; vs_pos = 4; v_adj = 2; max_scan = 2;
    start_addr = 14'h3FFC; skew_sel = 1;
    exp_hsw = '{2, 1}; exp_vsw = '{30, 160}; exp_frame = '{200, 200};
    frame_tag = "R7 frame length";
    start_cfg();
    run(1000);
    check("R3 address wrap", 0, seen_wrap, seen_wrap, 1);
    end_cfg(1);

    // Set B: immediate frame end, zero hsync width, skew 2
    h_total = 19; h_disp = 12; hs_pos = 2; sync_w = 8'h20;
    v_total = 5; v_disp = 3; vs_pos = 2; v_adj = 0; max_scan = 0;
    start_addr = 14'h0100; skew_sel = 2;
    exp_hsw = '{0, 15}; exp_vsw = '{40, -1}; exp_frame = '{120, -1};
    frame_tag = "R8 frame length";
    start_cfg();
    run(600);
    end_cfg(2);

    // Set C: row start reload, delay code 3
    h_total = 7; h_disp = 4; hs_pos = 5; sync_w = 8'h11;
    v_total = 3; v_disp = 3; vs_pos = 2; v_adj = 1; max_scan = 1;
    start_addr = 14'h1230; skew_sel = 3;
    exp_hsw = '{1, 0}; exp_vsw = '{8, -1}; exp_frame = '{72, -1};
    frame_tag = "R7 frame length";
    want_row = 1;
    start_cfg();
    run(400);
    check("R2 row seen", 0, row_done, row_done, 1);
    end_cfg(0);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule